// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block works out what a 32-bit core with branch delay slots must save and where it must jump when an exception is taken, and it restores state on a return from exception. The core gives it an exception request with a vector number, the address of the faulting instruction, a flag that says the instruction sat in a delay slot, the live status register, and a return strobe. One clock edge later the block drives a redirect strobe with the target address, a status-register load strobe with the new status value, and a strobe that tells the fetch logic to drop any pending delay-slot state. It keeps the saved exception PC, the saved status word and the error effective address in registers of its own.

The saved PC depends on the class of the exception. Faults that must be retried save the faulting address. Faults that complete their instruction save the next address. A delay-slot instruction moves the saved address back by one instruction so that the branch runs again. The handler address is the vector number times 256, on top of a high base when the status high-vector bit is set. A trap request enters no handler: it raises a halt pulse for the debug logic. An unknown vector number raises an error pulse and changes nothing. The block does no fetching, decoding or interrupt arbitration.

Top module: `exc_seq`

## Requirements
- R1: After synchronous reset the saved PC, saved status and error address read 0, and the redirect, status-load, delay-slot-clear, halt and error outputs are low.
- R2: A request with vector 0xE (trap) gives a one-cycle halt pulse. It gives no redirect, no status load and no delay-slot clear, and it leaves the saved PC, saved status and error address unchanged.
- R3: For vector 0xC (system call) and 0xD (floating-point), the saved PC becomes the faulting PC plus 4, or the faulting PC itself when the delay-slot flag is set.
- R4: For vectors 0x2 (bus error), 0x6 (alignment), 0x7 (illegal instruction) and 0xB (range), the saved PC becomes the faulting PC, or the faulting PC minus 4 when the delay-slot flag is set.
- R5: Vector 0x1 (reset) leaves the saved PC unchanged, but it still saves the status word and redirects to its handler.
- R6: On every entry the saved status takes the input status word. The status-load output carries that word with bit 13 (delay-slot exception) replaced by the delay-slot flag.
- R7: The entry redirect target is the vector number shifted left by 8. 0xF0000000 is added when bit 14 (high vector) of the input status word is 1.
- R8: Vector 0x7 loads the error address register with the faulting PC. No other vector changes it.
- R9: A return strobe redirects to the saved PC and loads the status register with the saved status, with bit 15 (fixed one) forced to 1.
- R10: The delay-slot-clear output pulses on every entry and every return.
- R11: A vector outside the set 0x1, 0x2, 0x6, 0x7, 0xB, 0xC, 0xD, 0xE gives a one-cycle error pulse and no other output or register change.
- R12: When an exception request and a return strobe arrive in the same cycle, the exception is served and the return is dropped.
- R13: Every result appears on the cycle after the request edge. Strobes last one cycle unless a new request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req_i | input | 1 | Exception request, one cycle |
| exc_vec_i | input | VEC_W | Exception vector number |
| fault_pc_i | input | XLEN | Address of the faulting instruction |
| in_dslot_i | input | 1 | Faulting instruction sits in a delay slot |
| sr_i | input | XLEN | Current status register |
| rfe_i | input | 1 | Return-from-exception strobe |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | XLEN | Redirect target |
| sr_load_o | output | 1 | Status register load strobe |
| sr_next_o | output | XLEN | Value for the status register |
| dslot_clr_o | output | 1 | Clear pending next-delay-slot state |
| halt_o | output | 1 | Debug halt pulse on trap |
| bad_vec_o | output | 1 | Unsupported vector pulse |
| epc_o | output | XLEN | Saved exception PC |
| esr_o | output | XLEN | Saved status register |
| eear_o | output | XLEN | Error effective address |

## Verification
Every output, strobe and saved register is registered once, so each result is due exactly one clock after the edge that samples the request. The bench drives a request on a falling edge, removes it on the next falling edge, and samples there, half a cycle after the edge that updates the outputs. It then samples one more falling edge later to check that the strobes have dropped. Stability checks for trap, unknown vectors and the reset vector compare the saved registers against the values the bench expects from the earlier requests.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam logic [7:0] EV_RESET   = 8'h01;
    localparam logic [7:0] EV_BUSERR  = 8'h02;
    localparam logic [7:0] EV_ALIGN   = 8'h06;
    localparam logic [7:0] EV_ILLEGAL = 8'h07;
    localparam logic [7:0] EV_RANGE   = 8'h0B;
    localparam logic [7:0] EV_SYSCALL = 8'h0C;
    localparam logic [7:0] EV_FPE     = 8'h0D;
    localparam logic [7:0] EV_TRAP    = 8'h0E;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ENTER,
        OP_TRAP,
        OP_BADVEC,
        OP_RETURN
    } op_e;

    typedef enum logic [1:0] {
        EPC_KEEP,
        EPC_SAME,
        EPC_NEXT
    } epc_rule_e;

    typedef struct packed {
        op_e       op;
        epc_rule_e rule;
        logic      load_eear;
    } dec_t;

    function automatic dec_t decode_req(logic req, logic rfe, logic [7:0] vec);
        dec_t d;
        d.op        = OP_IDLE;
        d.rule      = EPC_KEEP;
        d.load_eear = 1'b0;
        if (req) begin
            unique case (vec)
                EV_RESET: d.op = OP_ENTER;
                EV_SYSCALL, EV_FPE: begin
                    d.op   = OP_ENTER;
                    d.rule = EPC_NEXT;
                end
                EV_BUSERR, EV_ALIGN, EV_RANGE: begin
                    d.op   = OP_ENTER;
                    d.rule = EPC_SAME;
                end
                EV_ILLEGAL: begin
                    d.op        = OP_ENTER;
                    d.rule      = EPC_SAME;
                    d.load_eear = 1'b1;
                end
                EV_TRAP: d.op = OP_TRAP;
                default: d.op = OP_BADVEC;
            endcase
        end else if (rfe) begin
            d.op = OP_RETURN;
        end
        return d;
    endfunction

endpackage

// File: rtl/exc_decode.sv
module exc_decode
    import exc_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             req_i,
    input  logic             rfe_i,
    input  logic [VEC_W-1:0] vec_i,
    output dec_t             dec_o
);
    logic [7:0] vec_ext;

    assign vec_ext = 8'(vec_i);

    always_comb begin
        dec_o = decode_req(req_i, rfe_i, vec_ext);
    end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
    import exc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ILEN = 4
) (
    input  epc_rule_e        rule_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic             dslot_i,
    output logic             we_o,
    output logic [XLEN-1:0]  epc_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(ILEN);

    logic [XLEN-1:0] anchor;

    // A delay-slot fault points back at the branch so it is replayed.
    assign anchor = dslot_i ? (pc_i - STEP) : pc_i;

    always_comb begin
        we_o  = 1'b0;
        epc_o = anchor;
        unique case (rule_i)
            EPC_SAME: we_o = 1'b1;
            EPC_NEXT: begin
                we_o  = 1'b1;
                epc_o = anchor + STEP;
            end
            default: we_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            epc_we_i,
    input  logic [XLEN-1:0] epc_d_i,
    input  logic            esr_we_i,
    input  logic [XLEN-1:0] esr_d_i,
    input  logic            eear_we_i,
    input  logic [XLEN-1:0] eear_d_i,
    output logic [XLEN-1:0] epc_q_o,
    output logic [XLEN-1:0] esr_q_o,
    output logic [XLEN-1:0] eear_q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q_o  <= '0;
            esr_q_o  <= '0;
            eear_q_o <= '0;
        end else begin
            if (epc_we_i)  epc_q_o  <= epc_d_i;
            if (esr_we_i)  esr_q_o  <= esr_d_i;
            if (eear_we_i) eear_q_o <= eear_d_i;
        end
    end
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
    import exc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              VEC_W     = 5,
    parameter int              VEC_SHIFT = 8,
    parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000,
    parameter int              DSX_BIT   = 13,
    parameter int              EPH_BIT   = 14,
    parameter int              FO_BIT    = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [XLEN-1:0]  sr_i,
    input  logic             dslot_i,
    input  logic [XLEN-1:0]  epc_q_i,
    input  logic [XLEN-1:0]  esr_q_i,
    output logic             redirect_o,
    output logic [XLEN-1:0]  redirect_pc_o,
    output logic             sr_load_o,
    output logic [XLEN-1:0]  sr_next_o,
    output logic             dslot_clr_o,
    output logic             halt_o,
    output logic             bad_vec_o
);
    logic [XLEN-1:0] handler_pc;
    logic [XLEN-1:0] entry_sr;
    logic [XLEN-1:0] return_sr;

    assign handler_pc = (XLEN'(vec_i) << VEC_SHIFT) + (sr_i[EPH_BIT] ? HI_BASE : '0);

    always_comb begin
        entry_sr          = sr_i;
        entry_sr[DSX_BIT] = dslot_i;
        return_sr         = esr_q_i;
        return_sr[FO_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
            sr_load_o     <= 1'b0;
            sr_next_o     <= '0;
            dslot_clr_o   <= 1'b0;
            halt_o        <= 1'b0;
            bad_vec_o     <= 1'b0;
        end else begin
            redirect_o  <= 1'b0;
            sr_load_o   <= 1'b0;
            dslot_clr_o <= 1'b0;
            halt_o      <= 1'b0;
            bad_vec_o   <= 1'b0;
            unique case (op_i)
                OP_ENTER: begin
                    redirect_o    <= 1'b1;
                    redirect_pc_o <= handler_pc;
                    sr_load_o     <= 1'b1;
                    sr_next_o     <= entry_sr;
                    dslot_clr_o   <= 1'b1;
                end
                OP_RETURN: begin
                    redirect_o    <= 1'b1;
                    redirect_pc_o <= epc_q_i;
                    sr_load_o     <= 1'b1;
                    sr_next_o     <= return_sr;
                    dslot_clr_o   <= 1'b1;
                end
                OP_TRAP:   halt_o    <= 1'b1;
                OP_BADVEC: bad_vec_o <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              VEC_W     = 5,
    parameter int              ILEN      = 4,
    parameter int              VEC_SHIFT = 8,
    parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000,
    parameter int              DSX_BIT   = 13,
    parameter int              EPH_BIT   = 14,
    parameter int              FO_BIT    = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exc_req_i,
    input  logic [VEC_W-1:0] exc_vec_i,
    input  logic [XLEN-1:0]  fault_pc_i,
    input  logic             in_dslot_i,
    input  logic [XLEN-1:0]  sr_i,
    input  logic             rfe_i,
    output logic             redirect_o,
    output logic [XLEN-1:0]  redirect_pc_o,
    output logic             sr_load_o,
    output logic [XLEN-1:0]  sr_next_o,
    output logic             dslot_clr_o,
    output logic             halt_o,
    output logic             bad_vec_o,
    output logic [XLEN-1:0]  epc_o,
    output logic [XLEN-1:0]  esr_o,
    output logic [XLEN-1:0]  eear_o
);
    dec_t            dec;
    logic            epc_calc_we;
    logic [XLEN-1:0] epc_calc;
    logic            entering;

    exc_decode #(.VEC_W(VEC_W)) u_decode (
        .req_i (exc_req_i),
        .rfe_i (rfe_i),
        .vec_i (exc_vec_i),
        .dec_o (dec)
    );

    exc_epc_calc #(.XLEN(XLEN), .ILEN(ILEN)) u_epc (
        .rule_i  (dec.rule),
        .pc_i    (fault_pc_i),
        .dslot_i (in_dslot_i),
        .we_o    (epc_calc_we),
        .epc_o   (epc_calc)
    );

    assign entering = (dec.op == OP_ENTER);

    exc_state_regs #(.XLEN(XLEN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .epc_we_i  (entering && epc_calc_we),
        .epc_d_i   (epc_calc),
        .esr_we_i  (entering),
        .esr_d_i   (sr_i),
        .eear_we_i (entering && dec.load_eear),
        .eear_d_i  (fault_pc_i),
        .epc_q_o   (epc_o),
        .esr_q_o   (esr_o),
        .eear_q_o  (eear_o)
    );

    exc_redirect #(
        .XLEN(XLEN), .VEC_W(VEC_W), .VEC_SHIFT(VEC_SHIFT), .HI_BASE(HI_BASE),
        .DSX_BIT(DSX_BIT), .EPH_BIT(EPH_BIT), .FO_BIT(FO_BIT)
    ) u_redirect (
        .clk           (clk),
        .rst           (rst),
        .op_i          (dec.op),
        .vec_i         (exc_vec_i),
        .sr_i          (sr_i),
        .dslot_i       (in_dslot_i),
        .epc_q_i       (epc_o),
        .esr_q_i       (esr_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .sr_load_o     (sr_load_o),
        .sr_next_o     (sr_next_o),
        .dslot_clr_o   (dslot_clr_o),
        .halt_o        (halt_o),
        .bad_vec_o     (bad_vec_o)
    );
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int              XLEN      = 32,
    parameter int              VEC_W     = 5,
    parameter int              ILEN      = 4,
    parameter int              VEC_SHIFT = 8,
    parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000,
    parameter int              DSX_BIT   = 13,
    parameter int              EPH_BIT   = 14,
    parameter int              FO_BIT    = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             exc_req_i,
    input logic [VEC_W-1:0] exc_vec_i,
    input logic [XLEN-1:0]  fault_pc_i,
    input logic             in_dslot_i,
    input logic [XLEN-1:0]  sr_i,
    input logic             rfe_i,
    input logic             redirect_o,
    input logic [XLEN-1:0]  redirect_pc_o,
    input logic             sr_load_o,
    input logic [XLEN-1:0]  sr_next_o,
    input logic             dslot_clr_o,
    input logic             halt_o,
    input logic             bad_vec_o,
    input logic [XLEN-1:0]  epc_o,
    input logic [XLEN-1:0]  esr_o,
    input logic [XLEN-1:0]  eear_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(ILEN);

    logic [7:0] v;
    logic       is_next, is_same, is_reset, is_trap, is_entry;

    assign v        = 8'(exc_vec_i);
    assign is_next  = exc_req_i && (v == 8'h0C || v == 8'h0D);
    assign is_same  = exc_req_i && (v == 8'h02 || v == 8'h06 || v == 8'h07 || v == 8'h0B);
    assign is_reset = exc_req_i && (v == 8'h01);
    assign is_trap  = exc_req_i && (v == 8'h0E);
    assign is_entry = is_next || is_same || is_reset;

    AST_TRAP_HALT: assert property (@(posedge clk) disable iff (rst)
        is_trap |=> (halt_o && !redirect_o && !sr_load_o && $stable(epc_o) && $stable(esr_o) && $stable(eear_o))); // R2
    AST_HALT_EXCL: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> (!redirect_o && !dslot_clr_o)); // R2
    AST_NEXT_EPC: assert property (@(posedge clk) disable iff (rst)
        is_next |=> epc_o == ($past(fault_pc_i) + ($past(in_dslot_i) ? '0 : STEP))); // R3
    AST_SAME_EPC: assert property (@(posedge clk) disable iff (rst)
        is_same |=> epc_o == ($past(fault_pc_i) - ($past(in_dslot_i) ? STEP : '0))); // R4
    AST_RESET_EPC: assert property (@(posedge clk) disable iff (rst)
        is_reset |=> ($stable(epc_o) && redirect_o)); // R5
    AST_ESR_SAVE: assert property (@(posedge clk) disable iff (rst)
        is_entry |=> (esr_o == $past(sr_i) && sr_load_o && sr_next_o[DSX_BIT] == $past(in_dslot_i))); // R6
    AST_HANDLER: assert property (@(posedge clk) disable iff (rst)
        is_entry |=> redirect_pc_o == ((XLEN'($past(exc_vec_i)) << VEC_SHIFT) + ($past(sr_i[EPH_BIT]) ? HI_BASE : '0))); // R7
    AST_EEAR: assert property (@(posedge clk) disable iff (rst)
        (exc_req_i && v == 8'h07) |=> eear_o == $past(fault_pc_i)); // R8
    AST_RFE: assert property (@(posedge clk) disable iff (rst)
        (rfe_i && !exc_req_i) |=> (redirect_o && redirect_pc_o == $past(epc_o) && sr_next_o[FO_BIT] && dslot_clr_o)); // R9
    AST_BADVEC: assert property (@(posedge clk) disable iff (rst)
        (exc_req_i && !is_entry && !is_trap) |=> (bad_vec_o && !redirect_o && $stable(epc_o) && $stable(esr_o))); // R11
    AST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!exc_req_i && !rfe_i) |=> (!redirect_o && !halt_o && !bad_vec_o)); // R13
endmodule

bind exc_seq exc_seq_chk #(
    .XLEN(XLEN), .VEC_W(VEC_W), .ILEN(ILEN), .VEC_SHIFT(VEC_SHIFT), .HI_BASE(HI_BASE),
    .DSX_BIT(DSX_BIT), .EPH_BIT(EPH_BIT), .FO_BIT(FO_BIT)
) u_chk (.*);

// File: tb/tb_exc_seq.sv
module tb_exc_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        exc_req, in_dslot, rfe;
    logic [4:0]  exc_vec;
    logic [31:0] fault_pc, sr;
    logic        redirect, sr_load, dslot_clr, halt, bad_vec;
    logic [31:0] redirect_pc, sr_next, epc, esr, eear;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    exc_seq dut (
        .clk(clk), .rst(rst), .exc_req_i(exc_req), .exc_vec_i(exc_vec),
        .fault_pc_i(fault_pc), .in_dslot_i(in_dslot), .sr_i(sr), .rfe_i(rfe),
        .redirect_o(redirect), .redirect_pc_o(redirect_pc), .sr_load_o(sr_load),
        .sr_next_o(sr_next), .dslot_clr_o(dslot_clr), .halt_o(halt), .bad_vec_o(bad_vec),
        .epc_o(epc), .esr_o(esr), .eear_o(eear)
    );

    typedef struct packed {
        logic [4:0]  vec;
        logic [31:0] pc;
        logic        ds;
        logic [31:0] sr;
        logic [31:0] epc;
        logic [31:0] hpc;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        '{5'h0C, 32'h0000_1000, 1'b0, 32'h0000_8001, 32'h0000_1004, 32'h0000_0C00},
        '{5'h0C, 32'h0000_2000, 1'b1, 32'h0000_4000, 32'h0000_2000, 32'hF000_0C00},
        '{5'h0D, 32'h0000_3010, 1'b0, 32'h0000_0000, 32'h0000_3014, 32'h0000_0D00},
        '{5'h02, 32'h0000_4000, 1'b1, 32'h0000_4001, 32'h0000_3FFC, 32'hF000_0200},
        '{5'h06, 32'h0000_5000, 1'b0, 32'h0000_2000, 32'h0000_5000, 32'h0000_0600},
        '{5'h07, 32'h0000_6008, 1'b0, 32'h0000_0003, 32'h0000_6008, 32'h0000_0700},
        '{5'h0B, 32'h0000_7000, 1'b1, 32'h0000_4000, 32'h0000_6FFC, 32'hF000_0B00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Drive one request on a falling edge, drop it on the next, results are then valid.
    task automatic pulse(input logic req, input logic ret, input logic [4:0] v,
                         input logic [31:0] pc, input logic ds, input logic [31:0] s);
        @(negedge clk);
        exc_req = req; rfe = ret; exc_vec = v; fault_pc = pc; in_dslot = ds; sr = s;
        @(negedge clk);
        exc_req = 1'b0; rfe = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] x_eear, x_epc, x_esr, x_srn;
        rst = 1'b1; exc_req = 1'b0; rfe = 1'b0; exc_vec = '0;
        fault_pc = '0; in_dslot = 1'b0; sr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 epc", epc, 32'h0);
        chk("R1 esr", esr, 32'h0);
        chk("R1 eear", eear, 32'h0);
        chk("R1 strobes", {27'h0, redirect, sr_load, dslot_clr, halt, bad_vec}, 32'h0);

        x_eear = 32'h0;
        for (int i = 0; i < NV; i++) begin
            pulse(1'b1, 1'b0, TBL[i].vec, TBL[i].pc, TBL[i].ds, TBL[i].sr);
            if (TBL[i].vec == 5'h07) x_eear = TBL[i].pc;
            x_srn = TBL[i].sr;
            x_srn[13] = TBL[i].ds;
            chk("R3/R4 epc", epc, TBL[i].epc);
            chk("R7 handler", redirect_pc, TBL[i].hpc);
            chk("R6 esr", esr, TBL[i].sr);
            chk("R6 sr_next", sr_next, x_srn);
            chk("R6 sr_load", {31'h0, sr_load}, 32'h1);
            chk("R10 dslot_clr", {31'h0, dslot_clr}, 32'h1);
            chk("R8 eear", eear, x_eear);
            chk("R13 redirect", {30'h0, redirect, halt}, 32'h2);
        end
        @(negedge clk);
        chk("R13 pulses drop", {29'h0, redirect, sr_load, dslot_clr}, 32'h0);
        x_epc = epc; x_esr = esr;

        // R2 trap
        pulse(1'b1, 1'b0, 5'h0E, 32'h0000_8000, 1'b1, 32'h0000_FFFF);
        chk("R2 halt", {31'h0, halt}, 32'h1);
        chk("R2 no redirect", {29'h0, redirect, sr_load, dslot_clr}, 32'h0);
        chk("R2 epc kept", epc, x_epc);
        chk("R2 esr kept", esr, x_esr);
        chk("R2 eear kept", eear, x_eear);
        @(negedge clk);
        chk("R2 halt one cycle", {31'h0, halt}, 32'h0);

        // R5 reset vector
        pulse(1'b1, 1'b0, 5'h01, 32'h9999_0000, 1'b0, 32'h0000_4000);
        chk("R5 epc kept", epc, x_epc);
        chk("R5 esr saved", esr, 32'h0000_4000);
        chk("R5 handler", redirect_pc, 32'hF000_0100);
        chk("R8 eear untouched", eear, x_eear);

        // R9 return
        pulse(1'b0, 1'b1, 5'h00, 32'h0, 1'b0, 32'h0000_0000);
        chk("R9 target", redirect_pc, x_epc);
        chk("R9 sr_next", sr_next, 32'h0000_C000);
        chk("R9 strobes", {30'h0, redirect, sr_load}, 32'h3);
        chk("R10 dslot_clr on return", {31'h0, dslot_clr}, 32'h1);

        // R11 unsupported vector
        pulse(1'b1, 1'b0, 5'h03, 32'h0000_A000, 1'b0, 32'h0000_1234);
        chk("R11 bad_vec", {31'h0, bad_vec}, 32'h1);
        chk("R11 no redirect", {29'h0, redirect, sr_load, dslot_clr}, 32'h0);
        chk("R11 epc kept", epc, x_epc);
        chk("R11 esr kept", esr, 32'h0000_4000);
        @(negedge clk);
        chk("R11 one cycle", {31'h0, bad_vec}, 32'h0);

        // R12 exception wins over return
        pulse(1'b1, 1'b1, 5'h0C, 32'h0000_0100, 1'b0, 32'h0000_0000);
        chk("R12 target", redirect_pc, 32'h0000_0C00);
        chk("R12 epc", epc, 32'h0000_0104);
        chk("R12 sr_next", sr_next, 32'h0000_0000);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule